// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block turns a fast reference clock into the two timing enables a UART needs. Software programs a divisor made of a 16-bit whole part and a 6-bit fraction, in two separately written registers. The block then emits a stream of one-clock oversampling pulses whose average rate is sixteen times the baud rate. Every sixteenth of those pulses also raises a bit enable that paces the transmitter.

The ideal divisor is the reference frequency over sixteen times the baud rate. The fraction field holds the fractional part of that divisor scaled by 64 and rounded to nearest. For example, at 125 MHz and 115200 baud the whole part is 67 and the fraction is 52. Each oversampling period lasts either the whole part or one clock more. A 6-bit accumulator adds the fraction once per period, and its carry supplies the extra clock. As a result, any 64 consecutive periods span exactly 64 times the whole part plus the fraction. A larger divisor gives longer periods and a smaller one gives shorter periods.

Top module: `uart_frac_baudgen`

## Requirements
- R1: The whole-part register is 16 bits and the fraction register is 6 bits. Each is loaded from its own data port when its write strobe is high at a clock edge, and neither write disturbs the other register.
- R2: `tick16_o` is high for single clock cycles. Every oversampling period lasts either the whole part or the whole part plus one clock. The first period after the block starts from cleared counters lasts exactly the whole part.
- R3: With whole part I and fraction F, period number n (counting from 1 after a start) lasts I + floor(n*F/64) - floor((n-1)*F/64) clocks.
- R4: `bit_tick_o` is high together with the 16th, 32nd, 48th, ... oversampling pulse after a start, and is low in every other cycle.
- R5: A divisor write made during a period does not change that period. The new value sets the length of the first period that begins after the write is registered.
- R6: While the whole-part register holds zero, both outputs stay low and all counters are cleared. A later nonzero value starts afresh as in R2.
- R7: While `run_en` is low, both outputs stay low and all counters are cleared. Raising `run_en` again restarts the period numbering of R3 and the pulse count of R4.
- R8: A synchronous reset (`rst` high at a clock edge) clears both divisor registers and all counters.
- R9: Any 64 consecutive oversampling periods span exactly 64*I + F clocks. With I=67 and F=52 that is 4340 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Enables pulse generation |
| int_wr_en | input | 1 | Write strobe for the whole-part register |
| int_wr_data | input | 16 | Whole part of the divisor |
| frac_wr_en | input | 1 | Write strobe for the fraction register |
| frac_wr_data | input | 6 | Fraction of the divisor, in 1/64 units |
| tick16_o | output | 1 | Oversampling enable, one clock wide |
| bit_tick_o | output | 1 | Bit enable, every sixteenth oversampling pulse |

## Verification
A corrupted period counter appears as a wrong gap between oversampling pulses within a single period, which is at most one whole part plus one clock. A corrupted accumulator is quieter. It moves the extra clock to a different period, so the gap sequence departs from the floor formula within at most 64 periods, and the 64-period total drifts. A wrong sub-count in the divide-by-16 stage moves the bit enable off the 16th pulse, which is visible within sixteen pulses. The sweep compares every gap and every bit enable against the arithmetic for many small divisors.

// File: rtl/ufb_pkg.sv
package ufb_pkg;
    localparam int DEF_INT_W   = 16;
    localparam int DEF_FRAC_W  = 6;
    localparam int DEF_OVS_LOG = 4;
endpackage

// File: rtl/ufb_div_regs.sv
module ufb_div_regs #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              int_we,
    input  logic [INT_W-1:0]  int_wd,
    input  logic              frac_we,
    input  logic [FRAC_W-1:0] frac_wd,
    output logic [INT_W-1:0]  int_o,
    output logic [FRAC_W-1:0] frac_o
);
    typedef struct packed {
        logic [INT_W-1:0]  ival;
        logic [FRAC_W-1:0] fval;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (int_we)  r_d.ival = int_wd;
        if (frac_we) r_d.fval = frac_wd;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign int_o  = r_q.ival;
    assign frac_o = r_q.fval;

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (r_q.ival == '0 && r_q.fval == '0));

    assert_frac_kept_R1: assert property (@(posedge clk) disable iff (rst)
        (!frac_we && int_we) |=> $stable(r_q.fval));
endmodule

// File: rtl/ufb_period_gen.sv
module ufb_period_gen #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick_o
);
    localparam int CNT_W = INT_W + 1;
    localparam int SUM_W = FRAC_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
    } per_t;

    per_t s_d, s_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        s_d = s_q;
        sum = {1'b0, s_q.acc} + {1'b0, div_frac};
        if (!active) begin
            s_d = '0;
        end else if (s_q.cnt <= CNT_W'(1)) begin
            s_d.acc = sum[FRAC_W-1:0];
            s_d.cnt = CNT_W'(div_int) + CNT_W'(sum[FRAC_W]);
        end else begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign tick_o = active && (s_q.cnt == CNT_W'(1));

    assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
        (active && s_q.cnt > CNT_W'(1)) |=> (s_q.cnt == $past(s_q.cnt) - CNT_W'(1)));

    assert_idle_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !active |=> (s_q.cnt == '0 && s_q.acc == '0));

    assert_len_bound_R2: assert property (@(posedge clk) disable iff (rst)
        s_q.cnt <= CNT_W'(2 ** INT_W));
endmodule

// File: rtl/ufb_bit_div.sv
module ufb_bit_div #(
    parameter int OVS_LOG = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic tick_i,
    output logic bit_o
);
    typedef struct packed {
        logic [OVS_LOG-1:0] sub;
    } bd_t;

    bd_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (!active)     b_d.sub = '0;
        else if (tick_i) b_d.sub = b_q.sub + OVS_LOG'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) b_q <= '0;
        else     b_q <= b_d;
    end

    assign bit_o = tick_i && (&b_q.sub);

    assert_bit_with_tick_R4: assert property (@(posedge clk) disable iff (rst)
        bit_o |-> tick_i);

    assert_bit_wraps_R4: assert property (@(posedge clk) disable iff (rst)
        bit_o |=> (b_q.sub == '0));

    assert_idle_sub_R7: assert property (@(posedge clk) disable iff (rst)
        !active |=> (b_q.sub == '0));
endmodule

// File: rtl/uart_frac_baudgen.sv
module uart_frac_baudgen
    import ufb_pkg::*;
#(
    parameter int INT_W   = DEF_INT_W,
    parameter int FRAC_W  = DEF_FRAC_W,
    parameter int OVS_LOG = DEF_OVS_LOG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              int_wr_en,
    input  logic [INT_W-1:0]  int_wr_data,
    input  logic              frac_wr_en,
    input  logic [FRAC_W-1:0] frac_wr_data,
    output logic              tick16_o,
    output logic              bit_tick_o
);
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    logic              run_ok;
    logic              tick;

    ufb_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .int_we  (int_wr_en),
        .int_wd  (int_wr_data),
        .frac_we (frac_wr_en),
        .frac_wd (frac_wr_data),
        .int_o   (div_int),
        .frac_o  (div_frac)
    );

    assign run_ok = run_en && (div_int != '0);

    ufb_period_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) per_i (
        .clk      (clk),
        .rst      (rst),
        .active   (run_ok),
        .div_int  (div_int),
        .div_frac (div_frac),
        .tick_o   (tick)
    );

    ufb_bit_div #(.OVS_LOG(OVS_LOG)) bdiv_i (
        .clk    (clk),
        .rst    (rst),
        .active (run_ok),
        .tick_i (tick),
        .bit_o  (bit_tick_o)
    );

    assign tick16_o = tick;

    assert_zero_int_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (div_int == '0) |-> (!tick16_o && !bit_tick_o));

    assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> (!tick16_o && !bit_tick_o));
endmodule

// File: tb/uart_frac_baudgen_tb_top.sv
module uart_frac_baudgen_tb_top;
    localparam int IW = 16;
    localparam int FW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          run_en;
    logic          int_wr_en;
    logic [IW-1:0] int_wr_data;
    logic          frac_wr_en;
    logic [FW-1:0] frac_wr_data;
    logic          tick16_o;
    logic          bit_tick_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    uart_frac_baudgen dut_i (
        .clk          (clk),
        .rst          (rst),
        .run_en       (run_en),
        .int_wr_en    (int_wr_en),
        .int_wr_data  (int_wr_data),
        .frac_wr_en   (frac_wr_en),
        .frac_wr_data (frac_wr_data),
        .tick16_o     (tick16_o),
        .bit_tick_o   (bit_tick_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (cycles >= 150000);
        failures = failures + 1;
        $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int i, input int f, input int n);
        return i + (n * f) / 64 - ((n - 1) * f) / 64;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_int(input int v);
        int_wr_en = 1'b1;
        int_wr_data = IW'(v);
        step();
        int_wr_en = 1'b0;
    endtask

    task automatic wr_frac(input int v);
        frac_wr_en = 1'b1;
        frac_wr_data = FW'(v);
        step();
        frac_wr_en = 1'b0;
    endtask

    // cycles until the next tick16; records bit_tick at that tick and
    // counts stray bit_tick cycles without a tick
    task automatic gap(output int g, output int bit_at_tick, output int stray);
        g = 0;
        stray = 0;
        bit_at_tick = 0;
        for (int k = 0; k < 70000; k++) begin
            step();
            g = g + 1;
            if (tick16_o) begin
                bit_at_tick = int'(bit_tick_o);
                break;
            end
            if (bit_tick_o) stray = stray + 1;
        end
    endtask

    task automatic quiet(input int n, output int seen);
        seen = 0;
        for (int k = 0; k < n; k++) begin
            step();
            if (tick16_o || bit_tick_o) seen = seen + 1;
        end
    endtask

    task automatic sweep(input int i, input int f, input int nper);
        int g, b, s, tot, stray_sum, bad_gap, bad_bit;
        run_en = 1'b0;
        wr_int(i);
        wr_frac(f);
        run_en = 1'b1;
        tot = 0; stray_sum = 0; bad_gap = 0; bad_bit = 0;
        for (int n = 1; n <= nper; n++) begin
            gap(g, b, s);
            stray_sum = stray_sum + s;
            if (g != exp_len(i, f, n)) begin
                bad_gap = bad_gap + 1;
                $display("FAIL R3: I=%0d F=%0d period %0d actual=%0d expected=%0d",
                         i, f, n, g, exp_len(i, f, n));
            end
            if (b != int'(n % 16 == 0)) begin
                bad_bit = bad_bit + 1;
                $display("FAIL R4: I=%0d F=%0d pulse %0d bit actual=%0d expected=%0d",
                         i, f, n, b, int'(n % 16 == 0));
            end
            if (n >= 3 && n < 67) tot = tot + g;
        end
        checks = checks + 2;
        failures = failures + (bad_gap != 0 ? 1 : 0) + (bad_bit != 0 ? 1 : 0);
        check("R4 stray bit enable", stray_sum, 0);
        check("R9 64-period total", tot, 64 * i + f);
        run_en = 1'b0;
        step();
    endtask

    initial begin
        int g, b, s, seen;
        int fr_list[5] = '{0, 1, 21, 32, 63};
        rst = 1'b1; run_en = 1'b0;
        int_wr_en = 1'b0; int_wr_data = '0;
        frac_wr_en = 1'b0; frac_wr_data = '0;
        @(negedge clk);
        step();
        step();
        rst = 1'b0;

        // R8: reset state, registers zero so running gives nothing
        check("R8 tick after reset", int'(tick16_o), 0);
        check("R8 bit after reset", int'(bit_tick_o), 0);
        run_en = 1'b1;
        quiet(40, seen);
        check("R6 R8 zero divisor quiet", seen, 0);
        run_en = 1'b0;

        // R1 R2 R3 R4 R9: near-exhaustive small sweep
        for (int i = 1; i <= 4; i++)
            for (int j = 0; j < 5; j++)
                sweep(i, fr_list[j], 70);
        sweep(7, 45, 70);
        // R9: worked example 67 / 52
        sweep(67, 52, 70);

        // R1: writing only the whole part keeps the fraction (3,40 -> 5,40)
        wr_int(3); wr_frac(40);
        wr_int(5);
        run_en = 1'b1;
        gap(g, b, s); check("R1 period 1", g, 5);
        gap(g, b, s); check("R1 period 2 keeps fraction", g, 6);
        run_en = 1'b0; step();

        // R7: stop mid-run, stay quiet, restart fresh (I=3 F=40)
        wr_int(3);
        run_en = 1'b1;
        for (int n = 1; n <= 5; n++) gap(g, b, s);
        step();
        run_en = 1'b0;
        quiet(30, seen);
        check("R7 quiet while stopped", seen, 0);
        run_en = 1'b1;
        gap(g, b, s); check("R7 restart first period", g, 3);
        gap(g, b, s); check("R7 restart second period", g, 4);
        for (int n = 3; n <= 15; n++) gap(g, b, s);
        check("R7 no bit before 16th", b, 0);
        gap(g, b, s); check("R7 bit on 16th after restart", b, 1);

        // R6: zero whole part mid-run silences, nonzero restarts fresh
        wr_int(0);
        quiet(20, seen);
        check("R6 quiet with zero divisor", seen, 0);
        wr_int(3);
        gap(g, b, s); check("R6 fresh first period", g, 3);
        run_en = 1'b0; step();

        // R5: write during a period does not alter it (I=4 F=0, then 7)
        wr_int(4); wr_frac(0);
        run_en = 1'b1;
        gap(g, b, s); check("R5 first period", g, 4);
        step();
        wr_int(7);
        gap(g, b, s); check("R5 current period unchanged", g + 2, 4);
        gap(g, b, s); check("R5 next period uses new value", g, 7);

        // R8: reset mid-run clears registers
        rst = 1'b1;
        step();
        rst = 1'b0;
        quiet(20, seen);
        check("R8 quiet after reset with run_en high", seen, 0);
        run_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule